// File: doc/BRIEF.md
# Transceiver Node Mode Controller

This block is the mode sequencer of a bus transceiver node that combines a supply regulator with a single-wire bus driver and receiver. It consumes flags that analog comparators and filters have already reduced to logic levels. From them it decides which of five states the node is in: power-on reset, initialisation, normal operation, sleep and thermal shutdown. It then drives the enables for the regulator, the transmitter, the receiver and the bus wake-up detector.

Every flag crosses into the clock domain through a short synchroniser chain. Edges of the enable pin are detected after synchronisation. The current state leaves the block as a 3-bit code, so a separate reset-delay timer can count from the initialisation state. All outputs are registered and change on the same clock edge as the state code.

Top module: `lin_node_mode_ctrl`

## Requirements
- R1: The state code on `mode_o` is 0 for power-on reset, 1 for initialisation, 2 for normal, 3 for sleep and 4 for thermal shutdown. A synchronous reset gives code 0 with all four enables low.
- R2: Power-on reset is held until the supply-above-off flag is seen. The block then moves to initialisation. Initialisation moves to normal once the output-above-reset flag is seen, whatever level the enable pin has.
- R3: In normal mode, a falling edge of the enable pin enters sleep only if the enable pin has been seen high during that stay in normal. A low enable level on its own never causes sleep, including after a bus wake-up.
- R4: In sleep, a rising edge of the enable pin or a bus wake pulse moves the block to initialisation, and from there to normal.
- R5: The enables {regulator, transmitter, receiver, wake} are 0000 in reset and thermal shutdown, 1010 in initialisation, 1x10 in normal and 0011 in sleep.
- R6: The transmitter enable is high only in normal mode while the output-above-master-reset flag is high. Dropping that flag cancels transmission without a state change.
- R7: The over-temperature flag in normal or sleep enters thermal shutdown. While in thermal shutdown, enable-pin edges and bus wake pulses have no effect.
- R8: The temperature-recovered flag, with over-temperature low, leaves thermal shutdown. The block returns to sleep if it entered from sleep. Otherwise it goes through initialisation to normal. Enable and bus levels do not affect this.
- R9: The supply-below-on flag forces power-on reset from any state, ahead of every other condition.
- R10: Each flag passes through SYNC_STAGES flops. With the default of 2, an enable-pin change applied before clock edge 1 changes the state at edge 3 and not before.
- R11: In sleep, over-temperature takes priority over a simultaneous enable rising edge or bus wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_low_i | input | 1 | Supply below the undervoltage-on level |
| sup_ok_i | input | 1 | Supply above the undervoltage-off level |
| vcc_rst_ok_i | input | 1 | Regulator output above the reset threshold |
| vcc_mr_ok_i | input | 1 | Regulator output above the master-reset level |
| en_i | input | 1 | Enable pin level from the host |
| bus_wake_i | input | 1 | Qualified bus wake pulse |
| ot_i | input | 1 | Over-temperature flag |
| temp_rec_i | input | 1 | Temperature-recovered flag |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmitter enable (low forces recessive) |
| rx_en_o | output | 1 | Receiver enable |
| wake_en_o | output | 1 | Bus wake-up detector enable |
| mode_o | output | 3 | Current state code |

## Verification
The properties assume only that the flags are digital levels. They place no demands on input ordering, because the state checks cover only legal codes, legal successors and the output decode of each state. The stimulus holds every flag for at least several cycles, well beyond the synchroniser depth, so that pulses such as the bus wake are always captured. It never drives the two supply flags high together, because the comparators they stand for cannot both trip at once.

// File: rtl/lnmc_pkg.sv
package lnmc_pkg;

  typedef enum logic [2:0] {
    ST_POR = 3'd0,
    ST_INI = 3'd1,
    ST_RUN = 3'd2,
    ST_SLP = 3'd3,
    ST_HOT = 3'd4
  } mode_t;

  localparam int FLAG_N    = 8;
  localparam int F_SUPLOW  = 0;
  localparam int F_SUPOK   = 1;
  localparam int F_VRST    = 2;
  localparam int F_VMR     = 3;
  localparam int F_EN      = 4;
  localparam int F_WAKE    = 5;
  localparam int F_OT      = 6;
  localparam int F_REC     = 7;

  typedef struct packed {
    logic reg_en;
    logic tx_en;
    logic rx_en;
    logic wake_en;
  } drv_t;

  function automatic drv_t mode_drive(mode_t m, logic mr_ok);
    drv_t d;
    d = '0;
    case (m)
      ST_INI: begin
        d.reg_en = 1'b1;
        d.rx_en  = 1'b1;
      end
      ST_RUN: begin
        d.reg_en = 1'b1;
        d.tx_en  = mr_ok;
        d.rx_en  = 1'b1;
      end
      ST_SLP: begin
        d.rx_en   = 1'b1;
        d.wake_en = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lnmc_sync.sv
module lnmc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/lnmc_edge.sv
module lnmc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/lnmc_fsm.sv
module lnmc_fsm
  import lnmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sup_low,
  input  logic  sup_ok,
  input  logic  vrst_ok,
  input  logic  en_lvl,
  input  logic  en_rise,
  input  logic  en_fall,
  input  logic  wake,
  input  logic  ot,
  input  logic  rec,
  output mode_t state_o,
  output mode_t next_o
);
  mode_t st_q, st_d;
  logic  armed_q;     // enable seen high during the present stay in normal
  logic  from_slp_q;  // thermal shutdown was entered from sleep

  always_comb begin
    st_d = st_q;
    if (sup_low) begin
      st_d = ST_POR;
    end else begin
      case (st_q)
        ST_POR: if (sup_ok) st_d = ST_INI;
        ST_INI: if (vrst_ok) st_d = ST_RUN;
        ST_RUN: begin
          if (ot)                       st_d = ST_HOT;
          else if (en_fall && armed_q)  st_d = ST_SLP;
        end
        ST_SLP: begin
          if (ot)                       st_d = ST_HOT;
          else if (en_rise || wake)     st_d = ST_INI;
        end
        ST_HOT: if (rec && !ot) st_d = from_slp_q ? ST_SLP : ST_INI;
        default: st_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_POR;
      armed_q    <= 1'b0;
      from_slp_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= (st_q == ST_RUN && st_d == ST_RUN) ? (armed_q | en_lvl) : 1'b0;
      if (st_d == ST_HOT && st_q != ST_HOT)
        from_slp_q <= (st_q == ST_SLP);
    end
  end

  assign state_o = st_q;
  assign next_o  = st_d;
endmodule

// File: rtl/lnmc_outreg.sv
module lnmc_outreg
  import lnmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t next_i,
  input  logic  mr_ok,
  output drv_t  drv_o
);
  always_ff @(posedge clk) begin
    if (rst) drv_o <= '0;
    else     drv_o <= mode_drive(next_i, mr_ok);
  end
endmodule

// File: rtl/lin_node_mode_ctrl.sv
module lin_node_mode_ctrl
  import lnmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sup_low_i,
  input  logic       sup_ok_i,
  input  logic       vcc_rst_ok_i,
  input  logic       vcc_mr_ok_i,
  input  logic       en_i,
  input  logic       bus_wake_i,
  input  logic       ot_i,
  input  logic       temp_rec_i,
  output logic       reg_en_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       wake_en_o,
  output logic [2:0] mode_o
);
  logic [FLAG_N-1:0] raw, syn;
  logic              en_rise, en_fall;
  mode_t             state, next;
  drv_t              drv;

  always_comb begin
    raw           = '0;
    raw[F_SUPLOW] = sup_low_i;
    raw[F_SUPOK]  = sup_ok_i;
    raw[F_VRST]   = vcc_rst_ok_i;
    raw[F_VMR]    = vcc_mr_ok_i;
    raw[F_EN]     = en_i;
    raw[F_WAKE]   = bus_wake_i;
    raw[F_OT]     = ot_i;
    raw[F_REC]    = temp_rec_i;
  end

  lnmc_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
  );

  lnmc_edge u_en_edge (
    .clk(clk), .rst(rst), .lvl_i(syn[F_EN]), .rise_o(en_rise), .fall_o(en_fall)
  );

  lnmc_fsm u_fsm (
    .clk(clk), .rst(rst),
    .sup_low(syn[F_SUPLOW]), .sup_ok(syn[F_SUPOK]), .vrst_ok(syn[F_VRST]),
    .en_lvl(syn[F_EN]), .en_rise(en_rise), .en_fall(en_fall),
    .wake(syn[F_WAKE]), .ot(syn[F_OT]), .rec(syn[F_REC]),
    .state_o(state), .next_o(next)
  );

  lnmc_outreg u_out (
    .clk(clk), .rst(rst), .next_i(next), .mr_ok(syn[F_VMR]), .drv_o(drv)
  );

  assign reg_en_o  = drv.reg_en;
  assign tx_en_o   = drv.tx_en;
  assign rx_en_o   = drv.rx_en;
  assign wake_en_o = drv.wake_en;
  assign mode_o    = state;
endmodule

// File: rtl/lnmc_checker.sv
module lnmc_checker (
  input logic       clk,
  input logic       rst,
  input logic       reg_en,
  input logic       tx_en,
  input logic       rx_en,
  input logic       wake_en,
  input logic [2:0] mode
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4);

  a_r2_por_successor: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd0 |=> (mode == 3'd0 || mode == 3'd1));

  a_r5_sleep_drive: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd3 |-> (!reg_en && !tx_en && rx_en && wake_en));

  a_r5_hot_drive: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd4 |-> (!reg_en && !tx_en && !rx_en && !wake_en));

  a_r6_tx_only_normal: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> mode == 3'd2);

  a_r7_hot_successor: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd4 |=> (mode == 3'd4 || mode == 3'd3 || mode == 3'd1 || mode == 3'd0));

  a_r3_ini_never_sleeps: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd1 |=> mode != 3'd3);
endmodule

bind lin_node_mode_ctrl lnmc_checker u_chk (
  .clk(clk), .rst(rst), .reg_en(reg_en_o), .tx_en(tx_en_o),
  .rx_en(rx_en_o), .wake_en(wake_en_o), .mode(mode_o)
);

// File: tb/lin_node_mode_ctrl_bench.sv
module lin_node_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] fl = '0;  // {rec, ot, wake, en, vmr, vrst, sup_ok, sup_low}
  logic reg_en, tx_en, rx_en, wake_en;
  logic [2:0] mode;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lin_node_mode_ctrl u_lin_node_mode_ctrl (
    .clk(clk), .rst(rst),
    .sup_low_i(fl[0]), .sup_ok_i(fl[1]), .vcc_rst_ok_i(fl[2]), .vcc_mr_ok_i(fl[3]),
    .en_i(fl[4]), .bus_wake_i(fl[5]), .ot_i(fl[6]), .temp_rec_i(fl[7]),
    .reg_en_o(reg_en), .tx_en_o(tx_en), .rx_en_o(rx_en), .wake_en_o(wake_en),
    .mode_o(mode)
  );

  // {flags, expected mode, expected {reg, tx, rx, wake}}
  localparam logic [14:0] VEC [0:27] = '{
    {8'b0000_0000, 3'd0, 4'b0000},
    {8'b0000_1010, 3'd1, 4'b1010},
    {8'b0000_1110, 3'd2, 4'b1110},
    {8'b0000_1110, 3'd2, 4'b1110},
    {8'b0001_1110, 3'd2, 4'b1110},
    {8'b0000_1110, 3'd3, 4'b0011},
    {8'b0000_0010, 3'd3, 4'b0011},
    {8'b0010_0010, 3'd1, 4'b1010},
    {8'b0000_1110, 3'd2, 4'b1110},
    {8'b0000_1110, 3'd2, 4'b1110},
    {8'b0000_0110, 3'd2, 4'b1010},
    {8'b0001_1110, 3'd2, 4'b1110},
    {8'b0000_1110, 3'd3, 4'b0011},
    {8'b0001_1110, 3'd2, 4'b1110},
    {8'b0101_1110, 3'd4, 4'b0000},
    {8'b0100_1110, 3'd4, 4'b0000},
    {8'b0110_1110, 3'd4, 4'b0000},
    {8'b1000_1110, 3'd2, 4'b1110},
    {8'b0001_1110, 3'd2, 4'b1110},
    {8'b0000_1110, 3'd3, 4'b0011},
    {8'b0100_1110, 3'd4, 4'b0000},
    {8'b1000_1110, 3'd3, 4'b0011},
    {8'b0000_1101, 3'd0, 4'b0000},
    {8'b0000_1110, 3'd2, 4'b1110},
    {8'b0000_1101, 3'd0, 4'b0000},
    {8'b0000_1100, 3'd0, 4'b0000},
    {8'b0000_0010, 3'd1, 4'b1010},
    {8'b0000_1110, 3'd2, 4'b1110}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1, 2, 26, 27:     return "R2";
      3, 4, 5, 9, 11, 12:  return "R3";
      6, 7, 8, 13:         return "R4";
      10:                  return "R6";
      14, 15, 16, 20:      return "R7";
      17, 18, 19, 21:      return "R8";
      default:             return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [2:0] m_exp, logic [3:0] d_exp);
    checks++;
    if (mode !== m_exp || {reg_en, tx_en, rx_en, wake_en} !== d_exp) begin
      errors++;
      $display("FAIL %s: mode=%0d drive=%b expected mode=%0d drive=%b",
               tag, mode, {reg_en, tx_en, rx_en, wake_en}, m_exp, d_exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 3'd0, 4'b0000);

    for (int i = 0; i < 28; i++) begin
      fl = VEC[i][14:7];
      settle(8);
      check(row_tag(i), VEC[i][6:4], VEC[i][3:0]);
    end

    // R10: synchroniser latency on an enable falling edge
    fl = 8'b0001_1110;
    settle(8);
    fl = 8'b0000_1110;
    settle(2);
    check("R10", 3'd2, 4'b1110);
    settle(1);
    check("R10", 3'd3, 4'b0011);

    // R11: over-temperature beats a simultaneous local wake in sleep
    fl = 8'b0101_1110;
    settle(8);
    check("R11", 3'd4, 4'b0000);
    // R8: recovery returns to sleep; the high enable level does not wake it
    fl = 8'b1001_1110;
    settle(8);
    check("R8", 3'd3, 4'b0011);

    // R9: undervoltage overrides thermal shutdown
    fl = 8'b0101_1110;
    settle(8);
    check("R7", 3'd4, 4'b0000);
    fl = 8'b0101_1101;
    settle(8);
    check("R9", 3'd0, 4'b0000);

    // R1: reset in the middle of normal operation
    fl = 8'b0000_1110;
    settle(8);
    check("R2", 3'd2, 4'b1110);
    rst = 1'b1;
    settle(1);
    check("R1", 3'd0, 4'b0000);
    rst = 1'b0;
    settle(8);
    check("R2", 3'd2, 4'b1110);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule